// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that runs a whole list of transfers on its own once software has prepared it. There are three small memories of equal depth. One holds the transmit words, one the received words, and one a command byte per entry. Software fills the transmit and command entries and writes the index of the last entry to use. It then sets a start bit. The controller walks the entries from index 0 up to that last index. For each entry it shifts the transmit word out on MOSI and captures the MISO word into the receive entry with the same index.

Each command byte does two things. Its low bits choose which chip-select lines are driven active during the entry. Its top bit says whether chip select stays active into the following entry or is released after this one. Frame timing is set in two configuration registers. These give the word length, clock polarity and phase, the SCK divider, the delay from chip-select assertion to the first clock edge, and the idle time after each word. The start bit clears itself when the last entry is done, and a completion flag and the last executed index are reported in a status register. All storage and registers sit behind a simple single-cycle write bus with a combinational read path.

Top module: `spiq_master`

## Requirements
- R1: After reset, the configuration register reads 0x2000 (word length 8, everything else off), the run, queue-end and status registers read 0, all chip-select lines are high, and SCK is low.
- R2: Writing the run register (address 97) with bit 15 set, while configuration bit 15 (master enable) is set, starts the queue at entry 0. Entries are processed up to and including the index held in bits 12:8 of the queue-end register (address 98). Bit 15 of the run register reads 1 while the queue runs and clears itself when the last entry's idle time has elapsed.
- R3: Each entry sends the low N bits of its transmit word (address 0..31) on MOSI, most significant bit first. N comes from configuration bits 13:10, where 0 means 16.
- R4: The N bits received on MISO during entry i are stored right-aligned, with zero upper bits, in receive entry i (address 32..63). Receive entries past the end index are not written.
- R5: While entry i is active, the chip-select outputs (active low) carry the inverse of bits 3:0 of command entry i (address 64..95).
- R6: If command bit 7 is clear, all chip selects are released after the word for (idle time + 1) cycles. If it is set, chip select stays active and the next entry starts without the lead delay. At queue completion all chip selects are always released.
- R7: SCK toggles every D system clocks, where D is configuration bits 7:0 and 0 counts as 1. It idles at the level of configuration bit 9 (polarity). With configuration bit 8 (phase) clear, data is sampled on the leading edge of each bit; with it set, on the trailing edge. Each word has exactly 2N SCK edges.
- R8: From the cycle chip select becomes active after a release, the first SCK edge comes L + 1 + D cycles later, where L is run register bits 14:8. The idle time after each word is run register bits 7:0.
- R9: Status (address 99) bit 7 is set when the queue completes and is cleared by writing 1 to it. Status bits 4:0 hold the index of the last entry transferred.
- R10: While the queue runs, bus writes to the transmit, command, configuration, run and queue-end locations are ignored. A start request made while master enable is clear is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 7 | Word address: 0-31 transmit, 32-63 receive, 64-95 command, 96-99 registers |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Chip-select lines, active low |

## Verification
The bench sweeps all four polarity/phase combinations at one word length. These runs separate sampling on the leading edge from sampling on the trailing edge, and show whether the idle level follows polarity. Further runs use word lengths of 1, 5, 12 and 16 bits (the last through the field value 0), dividers of 0, 1, 3 and 4, and queue lengths of 1, 3, 4, 6 and 32 entries. These expose off-by-one errors in edge counting, in the end pointer and in the divider. A bench-side SPI slave model streams known response words and records MOSI bits and chip-select values at each sample edge. Command patterns mix held and released chip select, so the release count and the lead gap show whether continuation is honoured.

// File: rtl/spiq_pkg.sv
// Shared constants for the queued SPI master: address regions of the
// register/RAM bus, register slots and the sequencer state encoding.
package spiq_pkg;
    localparam logic [1:0] RGN_TX  = 2'd0;
    localparam logic [1:0] RGN_RX  = 2'd1;
    localparam logic [1:0] RGN_CMD = 2'd2;
    localparam logic [1:0] RGN_CTL = 2'd3;

    localparam logic [1:0] SLOT_CFG  = 2'd0;
    localparam logic [1:0] SLOT_RUN  = 2'd1;
    localparam logic [1:0] SLOT_QEND = 2'd2;
    localparam logic [1:0] SLOT_STAT = 2'd3;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_XFER = 2'd2,
        SQ_TAIL = 2'd3
    } sq_state_t;
endpackage

// File: rtl/spiq_baud.sv
// Half-period tick generator for SCK.
// Counts system clocks while a word is in flight and pulses tick once
// every div_eff cycles (a divider of 0 acts as 1). Assumes div is held
// stable while run is high.
module spiq_baud #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt_q;
    logic [DIVW-1:0] div_eff;

    assign div_eff = (div == '0) ? DIVW'(1) : div;
    assign tick    = run && (cnt_q == div_eff - DIVW'(1));

    // Cycle counter, cleared when idle and after every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIVW'(1);
    end

    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_eff != DIVW'(1)) |=> !tick);
endmodule

// File: rtl/spiq_shift.sv
// Single-word serial engine. On go it loads the low nbits of tx_word and
// runs 2*nbits SCK edges paced by tick, sampling MISO on the leading
// edge (cpha=0) or the trailing edge (cpha=1), MSB first. done pulses one
// cycle after the final edge with rx_word complete. Assumes go only
// arrives while idle and cpol/cpha/nbits are stable during a word.
module spiq_shift #(
    parameter int WORDW = 16,
    parameter int CW    = $clog2(WORDW) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [WORDW-1:0] tx_word,
    input  logic [CW-1:0]    nbits,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             tick,
    input  logic             miso,
    output logic             active,
    output logic             sck,
    output logic             mosi,
    output logic             done,
    output logic [WORDW-1:0] rx_word
);
    localparam int EW = CW + 1;

    logic             active_q, ph_q, mosi_q, done_q;
    logic [EW-1:0]    ecnt_q;
    logic [WORDW-1:0] tx_sr_q, rx_sr_q;
    logic [WORDW-1:0] aligned;
    logic [EW-1:0]    last_edge;
    logic             sample;

    assign aligned   = tx_word << (WORDW - int'(nbits));
    assign last_edge = {nbits, 1'b0} - EW'(1);
    assign sample    = (~ecnt_q[0]) ^ cpha;

    assign active  = active_q;
    assign sck     = cpol ^ ph_q;
    assign mosi    = mosi_q;
    assign done    = done_q;
    assign rx_word = rx_sr_q;

    // Word load, edge stepping, data shift and sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            ph_q     <= 1'b0;
            mosi_q   <= 1'b0;
            done_q   <= 1'b0;
            ecnt_q   <= '0;
            tx_sr_q  <= '0;
            rx_sr_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                active_q <= 1'b1;
                ph_q     <= 1'b0;
                ecnt_q   <= '0;
                rx_sr_q  <= '0;
                if (!cpha) begin
                    mosi_q  <= aligned[WORDW-1];
                    tx_sr_q <= aligned << 1;
                end else begin
                    tx_sr_q <= aligned;
                end
            end else if (active_q && tick) begin
                ph_q   <= ~ph_q;
                ecnt_q <= ecnt_q + EW'(1);
                if (sample) begin
                    rx_sr_q <= {rx_sr_q[WORDW-2:0], miso};
                end else begin
                    mosi_q  <= tx_sr_q[WORDW-1];
                    tx_sr_q <= tx_sr_q << 1;
                end
                if (ecnt_q == last_edge) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end
        end
    end

    // R7
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (sck == cpol));
    // R3
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active_q);
endmodule

// File: rtl/spiq_seq.sv
// Queue sequencer. Walks entries 0..end_idx: lead delay (skipped when
// chip select was held from the previous entry), word transfer, then
// idle time during which chip select is held or released per the
// entry's continuation bit. Drives chip selects combinationally from
// the current entry's pattern. Assumes the command and config inputs
// are frozen while run is high.
module spiq_seq
    import spiq_pkg::*;
#(
    parameter int IW  = 5,
    parameter int CSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [IW-1:0]  end_idx,
    input  logic [6:0]     lead,
    input  logic [7:0]     post,
    input  logic [CSW-1:0] cs_pat,
    input  logic           cmd_cont,
    input  logic           xfer_done,
    output logic [IW-1:0]  idx,
    output logic [CSW-1:0] cs_n,
    output logic           go,
    output logic           rx_we,
    output logic           fin
);
    sq_state_t     state_q;
    logic [IW-1:0] idx_q;
    logic [7:0]    cnt_q;
    logic          hold_q;
    logic          tail_end;
    logic          cs_on;

    assign tail_end = (state_q == SQ_TAIL) && (cnt_q == post);
    assign go       = (state_q == SQ_LEAD) && (hold_q || cnt_q == {1'b0, lead});
    assign rx_we    = (state_q == SQ_XFER) && xfer_done;
    assign fin      = tail_end && (idx_q == end_idx);
    assign cs_on    = (state_q == SQ_LEAD) || (state_q == SQ_XFER) ||
                      ((state_q == SQ_TAIL) && hold_q);
    assign cs_n     = cs_on ? ~cs_pat : '1;
    assign idx      = idx_q;

    // Entry walk: state, index, delay counter and held-select flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            hold_q  <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (run) begin
                        state_q <= SQ_LEAD;
                        idx_q   <= '0;
                        cnt_q   <= '0;
                        hold_q  <= 1'b0;
                    end
                end
                SQ_LEAD: begin
                    if (go) state_q <= SQ_XFER;
                    else    cnt_q   <= cnt_q + 8'd1;
                end
                SQ_XFER: begin
                    if (xfer_done) begin
                        state_q <= SQ_TAIL;
                        cnt_q   <= '0;
                        hold_q  <= cmd_cont;
                    end
                end
                SQ_TAIL: begin
                    if (tail_end) begin
                        cnt_q <= '0;
                        if (idx_q == end_idx) begin
                            state_q <= SQ_IDLE;
                            hold_q  <= 1'b0;
                        end else begin
                            state_q <= SQ_LEAD;
                            idx_q   <= idx_q + IW'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q + 8'd1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R4
    done_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (state_q == SQ_XFER));
    // R2
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_IDLE) |-> (idx_q <= end_idx));
endmodule

// File: rtl/spiq_master.sv
// Queued SPI master top: transmit/receive/command storage, configuration
// registers and status, wired to the sequencer, bit engine and baud
// generator. Bus writes take effect at the clock edge; reads are
// combinational. While the run bit is set, only status flag clears are
// accepted.
module spiq_master
    import spiq_pkg::*;
#(
    parameter int QDEPTH = 32,
    parameter int WORDW  = 16,
    parameter int CSW    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [$clog2(QDEPTH)+1:0] bus_addr,
    input  logic [15:0]               bus_wdata,
    output logic [15:0]               bus_rdata,
    output logic                      spi_sck,
    output logic                      spi_mosi,
    input  logic                      spi_miso,
    output logic [CSW-1:0]            spi_cs_n
);
    localparam int IW = $clog2(QDEPTH);
    localparam int BW = $clog2(WORDW);
    localparam int CW = BW + 1;

    logic [WORDW-1:0] tx_mem [QDEPTH];
    logic [WORDW-1:0] rx_mem [QDEPTH];
    logic [7:0]       cmd_mem[QDEPTH];
    logic [15:0]      cfg_q, run_q;
    logic [IW-1:0]    qend_q, last_idx_q;
    logic             fin_flag_q;

    logic [1:0]       region;
    logic [IW-1:0]    slot;
    logic             busy, wr_ok, reg_hit;
    logic [BW-1:0]    len_field;
    logic [CW-1:0]    nbits;

    logic [IW-1:0]    seq_idx;
    logic             seq_go, seq_rx_we, seq_fin;
    logic             sh_active, sh_done, tick;
    logic [WORDW-1:0] rx_word;

    assign region    = bus_addr[IW+1:IW];
    assign slot      = bus_addr[IW-1:0];
    assign busy      = run_q[15];
    assign wr_ok     = bus_we && !busy;
    assign reg_hit   = (region == RGN_CTL) && (slot[IW-1:2] == '0);
    assign len_field = cfg_q[10 +: BW];
    assign nbits     = (len_field == '0) ? CW'(WORDW) : CW'(len_field);

    // Transmit and command storage, written by software when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QDEPTH; i++) begin
                tx_mem[i]  <= '0;
                cmd_mem[i] <= '0;
            end
        end else if (wr_ok && region == RGN_TX) begin
            tx_mem[slot] <= bus_wdata[WORDW-1:0];
        end else if (wr_ok && region == RGN_CMD) begin
            cmd_mem[slot] <= bus_wdata[7:0];
        end
    end

    // Receive storage, written by the queue at the end of each word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < QDEPTH; i++) rx_mem[i] <= '0;
        end else if (seq_rx_we) begin
            rx_mem[seq_idx] <= rx_word;
        end
    end

    // Configuration, run and queue-end registers; run bit self-clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= 16'h2000;
            run_q  <= '0;
            qend_q <= '0;
        end else begin
            if (seq_fin) run_q[15] <= 1'b0;
            if (wr_ok && reg_hit) begin
                unique case (slot[1:0])
                    SLOT_CFG:  cfg_q <= bus_wdata;
                    SLOT_RUN:  run_q <= {bus_wdata[15] & cfg_q[15], bus_wdata[14:0]};
                    SLOT_QEND: qend_q <= bus_wdata[8 +: IW];
                    default: ;
                endcase
            end
        end
    end

    // Status: completion flag (write-1-to-clear) and last entry index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_flag_q <= 1'b0;
            last_idx_q <= '0;
        end else begin
            if (seq_fin)
                fin_flag_q <= 1'b1;
            else if (bus_we && reg_hit && slot[1:0] == SLOT_STAT && bus_wdata[7])
                fin_flag_q <= 1'b0;
            if (seq_rx_we) last_idx_q <= seq_idx;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (region)
            RGN_TX:  bus_rdata = 16'(tx_mem[slot]);
            RGN_RX:  bus_rdata = 16'(rx_mem[slot]);
            RGN_CMD: bus_rdata = 16'(cmd_mem[slot]);
            default: begin
                if (reg_hit) begin
                    unique case (slot[1:0])
                        SLOT_CFG:  bus_rdata = cfg_q;
                        SLOT_RUN:  bus_rdata = run_q;
                        SLOT_QEND: bus_rdata = 16'(qend_q) << 8;
                        default:   bus_rdata = 16'(last_idx_q) | (16'(fin_flag_q) << 7);
                    endcase
                end
            end
        endcase
    end

    spiq_seq #(.IW(IW), .CSW(CSW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .end_idx   (qend_q),
        .lead      (run_q[14:8]),
        .post      (run_q[7:0]),
        .cs_pat    (cmd_mem[seq_idx][CSW-1:0]),
        .cmd_cont  (cmd_mem[seq_idx][7]),
        .xfer_done (sh_done),
        .idx       (seq_idx),
        .cs_n      (spi_cs_n),
        .go        (seq_go),
        .rx_we     (seq_rx_we),
        .fin       (seq_fin)
    );

    spiq_shift #(.WORDW(WORDW), .CW(CW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (seq_go),
        .tx_word (tx_mem[seq_idx]),
        .nbits   (nbits),
        .cpol    (cfg_q[9]),
        .cpha    (cfg_q[8]),
        .tick    (tick),
        .miso    (spi_miso),
        .active  (sh_active),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_word (rx_word)
    );

    spiq_baud #(.DIVW(8)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_active),
        .div   (cfg_q[7:0]),
        .tick  (tick)
    );

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q[15]) |-> $past(seq_fin));
    // R6
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n == '1));
    // R9
    fin_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fin_flag_q) |-> $past(seq_fin));
    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(cfg_q));
endmodule

// File: tb/spiq_master_test.sv
// Self-checking bench: SPI slave model plus configuration sweeps.
module spiq_master_test;
    logic        clk = 1'b0;
    logic        rst_n, bus_we, spi_sck, spi_mosi, spi_miso;
    logic [6:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic [3:0]  spi_cs_n;

    always #5 clk = ~clk;

    spiq_master uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit all_done = 0, wd_fired = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc > 150000 && !all_done && !wd_fired) begin
            wd_fired = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 7'(a); bus_wdata = 16'(d); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = 7'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    function automatic int txv(int i, int s);  return (i * 'h3B1 + s * 'h55 + 7) & 'hFFFF; endfunction
    function automatic int rspv(int i, int s); return ((i * 'h1D7) ^ (s * 'h9C3)) & 'hFFFF; endfunction
    function automatic int patv(int i, int s); return ((i * 5 + s) % 15) + 1; endfunction
    function automatic int contv(int i, int s); return (((i + s) % 3) != 0) ? 1 : 0; endfunction

    // slave model state
    bit          mon_on = 0, gap_armed = 0;
    int          cfg_n = 8, cfg_div = 1, e;
    bit          cfg_cpol = 0, cfg_cpha = 0, ld;
    logic [15:0] rsp [32];
    logic [15:0] cap_word [32];
    logic [3:0]  cs_at [32];
    int          cap_ptr, drv_ptr, edges, bad_gap, rel_cnt, first_gap, fall_cyc, last_edge_cyc;
    logic        prev_sck;
    logic [3:0]  prev_cs;

    function automatic logic stream_bit(int p);
        int ent = p / cfg_n;
        int b = cfg_n - 1 - (p % cfg_n);
        if (ent >= 32) return 1'b0;
        return rsp[ent][b];
    endfunction

    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_cs == 4'hF && spi_cs_n != 4'hF) begin
                fall_cyc = cyc;
                if (first_gap < 0) gap_armed = 1;
            end
            if (prev_cs != 4'hF && spi_cs_n == 4'hF) rel_cnt++;
            if (spi_sck !== prev_sck) begin
                ld = (spi_sck != cfg_cpol);
                if (gap_armed) begin first_gap = cyc - fall_cyc; gap_armed = 0; end
                if ((edges % (2 * cfg_n)) != 0 && (cyc - last_edge_cyc) != cfg_div) bad_gap++;
                last_edge_cyc = cyc;
                edges++;
                if (ld ^ cfg_cpha) begin
                    e = cap_ptr / cfg_n;
                    if (e < 32) begin
                        cap_word[e] = {cap_word[e][14:0], spi_mosi};
                        cs_at[e] = spi_cs_n;
                    end
                    cap_ptr++;
                end else if (!cfg_cpha) begin
                    drv_ptr++;
                    spi_miso = stream_bit(drv_ptr);
                end else begin
                    spi_miso = stream_bit(drv_ptr);
                    drv_ptr++;
                end
            end
        end
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
    end

    task automatic run_queue(input int cpol, input int cpha, input int nf, input int dv,
                             input int endp, input int lead, input int post, input int seed,
                             input bit tamper);
        int n, deff, mask, v, r, cfgw, exp_rel;
        n = (nf == 0) ? 16 : nf;
        deff = (dv == 0) ? 1 : dv;
        mask = (1 << n) - 1;
        for (int i = 0; i < 32; i++) begin
            wr(i, txv(i, seed));
            wr(64 + i, (contv(i, seed) << 7) | patv(i, seed));
            rsp[i] = 16'(rspv(i, seed));
            cap_word[i] = '0;
            cs_at[i] = '0;
        end
        cfgw = 'h8000 | (nf << 10) | (cpol << 9) | (cpha << 8) | dv;
        wr(96, cfgw);
        wr(98, endp << 8);
        cfg_cpol = 1'(cpol); cfg_cpha = 1'(cpha); cfg_n = n; cfg_div = deff;
        cap_ptr = 0; drv_ptr = 0; edges = 0; bad_gap = 0; rel_cnt = 0;
        first_gap = -1; gap_armed = 0;
        spi_miso = cpha ? 1'b0 : stream_bit(0);
        @(negedge clk);
        mon_on = 1;
        wr(97, 'h8000 | (lead << 8) | post);
        if (tamper) begin
            wr(0, 'hAAAA);
            wr(98, 'h1F00);
            wr(96, 0);
        end
        v = 'h8000;
        for (int k = 0; k < 20000; k++) begin
            rd(97, v);
            if (v[15] == 1'b0) break;
        end
        repeat (3) @(negedge clk);
        mon_on = 0;
        // R2: start bit self-clears at completion
        chk(v[15] == 1'b0, "R2 run bit self-clear", v, 0);
        // R9: completion flag and last index
        rd(99, r);
        chk(r == ('h80 | endp), "R9 status after run", r, 'h80 | endp);
        for (int i = 0; i <= endp; i++) begin
            rd(32 + i, r);
            chk(r == (rspv(i, seed) & mask), "R4 received word", r, rspv(i, seed) & mask);
            chk(int'(cap_word[i]) == (txv(i, seed) & mask), "R3 MOSI word",
                int'(cap_word[i]), txv(i, seed) & mask);
            chk(int'(cs_at[i]) == (~patv(i, seed) & 'hF), "R5 chip-select pattern",
                int'(cs_at[i]), ~patv(i, seed) & 'hF);
        end
        exp_rel = 1;
        for (int i = 0; i < endp; i++) if (contv(i, seed) == 0) exp_rel++;
        chk(rel_cnt == exp_rel, "R6 chip-select releases", rel_cnt, exp_rel);
        chk(edges == 2 * n * (endp + 1), "R7 SCK edge count", edges, 2 * n * (endp + 1));
        chk(bad_gap == 0, "R7 SCK half period", bad_gap, 0);
        chk(spi_sck == 1'(cpol), "R7 SCK idle level", int'(spi_sck), cpol);
        chk(first_gap == lead + 1 + deff, "R8 lead delay", first_gap, lead + 1 + deff);
        chk(spi_cs_n == 4'hF, "R6 release at end", int'(spi_cs_n), 'hF);
        if (tamper) begin
            rd(0, r);  chk(r == txv(0, seed), "R10 tx write ignored", r, txv(0, seed));
            rd(98, r); chk(r == (endp << 8), "R10 queue-end write ignored", r, endp << 8);
            rd(96, r); chk(r == cfgw, "R10 config write ignored", r, cfgw);
        end
        // R9: write 1 clears the completion flag
        wr(99, 'h80);
        rd(99, r);
        chk(r == endp, "R9 flag clear", r, endp);
    endtask

    initial begin
        int r;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; spi_miso = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(96, r); chk(r == 'h2000, "R1 config reset", r, 'h2000);
        rd(97, r); chk(r == 0, "R1 run reset", r, 0);
        rd(98, r); chk(r == 0, "R1 queue-end reset", r, 0);
        rd(99, r); chk(r == 0, "R1 status reset", r, 0);
        chk(spi_cs_n == 4'hF, "R1 chip selects high", int'(spi_cs_n), 'hF);
        chk(spi_sck == 1'b0, "R1 SCK low", int'(spi_sck), 0);

        run_queue(0, 0, 8, 2, 5, 3, 1, 1, 1'b1);
        rd(38, r); chk(r == 0, "R4 entry past end untouched", r, 0);
        run_queue(0, 1, 8, 2, 5, 3, 1, 2, 1'b0);
        run_queue(1, 0, 8, 2, 5, 3, 1, 3, 1'b0);
        run_queue(1, 1, 8, 2, 5, 3, 1, 4, 1'b0);
        run_queue(0, 0, 0, 1, 31, 0, 0, 5, 1'b0);
        run_queue(1, 1, 5, 0, 0, 2, 4, 6, 1'b0);
        run_queue(0, 1, 1, 3, 3, 1, 2, 7, 1'b0);
        run_queue(1, 0, 12, 4, 2, 5, 0, 8, 1'b0);

        // R10: start ignored while master enable is clear
        wr(96, 'h2000);
        wr(97, 'h8000);
        rd(97, r); chk(r[15] == 1'b0, "R10 start without enable", r, 0);
        repeat (5) @(negedge clk);
        chk(spi_cs_n == 4'hF, "R10 no chip select without enable", int'(spi_cs_n), 'hF);

        all_done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule